// File: doc/BRIEF.md
# Bus Data Inversion Codec

This block sits between a 64-bit internal data path and an external data bus whose data lines and inversion flags are active low. A logical 1 on such a line is driven as an electrical low. The transmit side splits each beat into four 16-bit groups. For each group it counts how many lines would be pulled low. If that count is above half the group, it sends the group inverted and drives that group's flag low. The receive side reads the flags that arrive with a beat and undoes the inversion of every flagged group, so the internal path gets the original word back.

Each direction is a stream with a valid/ready handshake and one register stage. A beat is accepted when valid and ready are both high in the same cycle. An output beat is presented until its consumer raises ready. The stage accepts a new beat only when it is empty or when its current beat is leaving in the same cycle. If the consumer holds ready low, the stage keeps its beat unchanged and drops its own ready, so back-pressure reaches the producer with no extra delay. When no beat is present, the transmit lines rest at the electrical high idle level and the receive data rests at zero.

Top module: `bdi_codec`

## Requirements
- R1: Data bit i belongs to group i/16 (group k is bits 16k+15..16k), and flag bit k on both `bus_flg_o` and `bus_flg_i` belongs to group k.
- R2: All bus ports carry electrical levels. A logical 1 appears as 0 on `bus_dat_o`. A flag bit of 0 means "group inverted" and a flag bit of 1 means "group sent as is".
- R3: A group with 9 or more logical ones is sent inverted, so its bus lines equal the logical data and its flag is 0. A group with 8 or fewer ones, including exactly 8, is sent plainly, so its bus lines are the complement of the data and its flag is 1.
- R4: On `bus_dat_o`, no 16-bit group ever has more than 8 lines at 0. A group whose flag is 0 has at most 7 lines at 0.
- R5: The decision for each group depends only on that group's bits in the same beat. It does not depend on other groups or on earlier beats.
- R6: The receive side outputs, for each group, the bus lines themselves when the group's flag is 0, and the complement of the bus lines when the flag is 1. Decoding an encoded beat therefore returns the original word.
- R7: With ready high, a beat accepted on the transmit or receive input appears on that side's output, with valid high, exactly one clock later.
- R8: While an output has valid high and ready low, that output's data, flags and valid do not change, and the input-side ready of that path is 0.
- R9: In a cycle with no beat present, the transmit side drives all data and flag lines to 1 with `bus_valid_o` at 0. The receive side then drives `rx_data_o` to 0 with `rx_valid_o` at 0.
- R10: Synchronous active-high reset puts both paths in the idle state of R9, with both input readies at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid_i | input | 1 | Transmit beat present |
| tx_ready_o | output | 1 | Transmit stage can take a beat |
| tx_data_i | input | 64 | Logical transmit word |
| bus_valid_o | output | 1 | Encoded beat present on bus outputs |
| bus_ready_i | input | 1 | Bus side takes the encoded beat |
| bus_dat_o | output | 64 | Encoded data, electrical levels |
| bus_flg_o | output | 4 | Inversion flags, 0 = group inverted |
| bus_valid_i | input | 1 | Received beat present |
| bus_ready_o | output | 1 | Receive stage can take a beat |
| bus_dat_i | input | 64 | Received data, electrical levels |
| bus_flg_i | input | 4 | Received inversion flags, 0 = group inverted |
| rx_valid_o | output | 1 | Decoded beat present |
| rx_ready_i | input | 1 | Consumer takes the decoded beat |
| rx_data_o | output | 64 | Decoded logical word |

## Verification
An encoded beat is due one clock edge after it is accepted, and the decoded word is due one edge after the bus beat is handed to the receive side. Inputs are driven on the falling edge. The bench checks each output at the next falling edge after the rising edge that captured the beat, so every result is sampled half a cycle after its register loads. The sweep walks every ones-count from 0 to 16 in each group, together with rotated bit positions and pseudo-random words. Each encoded beat is fed back through the receive side and compared with the original word one edge later. The idle level is checked in the bubble cycle that follows. Stall checks hold ready low for several cycles and look at every cycle of the stall, then release ready and expect the waiting beat one edge later.

// File: rtl/bdi_pkg.sv
package bdi_pkg;
  localparam int unsigned DEF_DATA_W = 64;
  localparam int unsigned DEF_GRP_W  = 16;

  // A group flips when strictly more than half of its lines would be low.
  function automatic int unsigned flip_threshold(int unsigned grp_w);
    return grp_w / 2 + 1;
  endfunction
endpackage

// File: rtl/bdi_grp_enc.sv
module bdi_grp_enc #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] dat_i,   // logical bits
  output logic [W-1:0] lines_o, // electrical levels
  output logic         flag_o   // electrical flag, 0 = inverted
);
  localparam int unsigned CW  = $clog2(W + 1);
  localparam int unsigned THR = bdi_pkg::flip_threshold(W);

  logic [CW-1:0] ones;
  logic          flip;

  always_comb begin
    ones = '0;
    for (int i = 0; i < int'(W); i++) ones = ones + CW'(dat_i[i]);
  end

  assign flip    = (ones >= CW'(THR));
  // Plain group: each logical 1 is a low line. Flipped group: levels follow data.
  assign lines_o = flip ? dat_i : ~dat_i;
  assign flag_o  = ~flip;
endmodule

// File: rtl/bdi_grp_dec.sv
module bdi_grp_dec #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] lines_i, // electrical levels
  input  logic         flag_i,  // electrical flag, 0 = inverted
  output logic [W-1:0] dat_o    // logical bits
);
  assign dat_o = flag_i ? ~lines_i : lines_i;
endmodule

// File: rtl/bdi_stage.sv
module bdi_stage #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= IDLE;
    end else if (in_ready) begin
      out_valid <= in_valid;
      out_data  <= in_valid ? in_data : IDLE;
    end
  end

  // R8: a stalled beat stays put
  a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9: an empty stage presents its idle level
  a_r9_bubble_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == IDLE));
endmodule

// File: rtl/bdi_codec.sv
module bdi_codec #(
  parameter int unsigned DATA_W = bdi_pkg::DEF_DATA_W,
  parameter int unsigned GRP_W  = bdi_pkg::DEF_GRP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic [DATA_W-1:0] bus_dat_o,
  output logic [DATA_W/GRP_W-1:0] bus_flg_o,
  input  logic              bus_valid_i,
  output logic              bus_ready_o,
  input  logic [DATA_W-1:0] bus_dat_i,
  input  logic [DATA_W/GRP_W-1:0] bus_flg_i,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam int unsigned N_GRP = DATA_W / GRP_W;
  localparam int unsigned TX_W  = DATA_W + N_GRP;
  localparam int unsigned HALF  = GRP_W / 2;

  logic [DATA_W-1:0] enc_lines;
  logic [N_GRP-1:0]  enc_flags;
  logic [DATA_W-1:0] dec_data;
  logic [TX_W-1:0]   tx_word;

  for (genvar g = 0; g < int'(N_GRP); g++) begin : g_grp
    bdi_grp_enc #(.W(GRP_W)) u_enc (
      .dat_i  (tx_data_i[g*GRP_W +: GRP_W]),
      .lines_o(enc_lines[g*GRP_W +: GRP_W]),
      .flag_o (enc_flags[g])
    );
    bdi_grp_dec #(.W(GRP_W)) u_dec (
      .lines_i(bus_dat_i[g*GRP_W +: GRP_W]),
      .flag_i (bus_flg_i[g]),
      .dat_o  (dec_data[g*GRP_W +: GRP_W])
    );

    // R4: driven-low lines per group never exceed half
    a_r4_lows_cap: assert property (@(posedge clk) disable iff (rst)
      $countones(~bus_dat_o[g*GRP_W +: GRP_W]) <= int'(HALF));

    // R3: a flipped group came from a majority, so few lows remain
    a_r3_flip_strict: assert property (@(posedge clk) disable iff (rst)
      !bus_flg_o[g] |-> ($countones(~bus_dat_o[g*GRP_W +: GRP_W]) < int'(HALF)));
  end

  bdi_stage #(.W(TX_W), .IDLE('1)) u_tx_stage (
    .clk      (clk),
    .rst      (rst),
    .in_valid (tx_valid_i),
    .in_ready (tx_ready_o),
    .in_data  ({enc_flags, enc_lines}),
    .out_valid(bus_valid_o),
    .out_ready(bus_ready_i),
    .out_data (tx_word)
  );

  assign bus_dat_o = tx_word[DATA_W-1:0];
  assign bus_flg_o = tx_word[TX_W-1:DATA_W];

  bdi_stage #(.W(DATA_W), .IDLE('0)) u_rx_stage (
    .clk      (clk),
    .rst      (rst),
    .in_valid (bus_valid_i),
    .in_ready (bus_ready_o),
    .in_data  (dec_data),
    .out_valid(rx_valid_o),
    .out_ready(rx_ready_i),
    .out_data (rx_data_o)
  );

  // R7: an accepted beat is presented on the next cycle
  a_r7_tx_latency: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_i && tx_ready_o) |=> bus_valid_o);
  a_r7_rx_latency: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_i && bus_ready_o) |=> rx_valid_o);
endmodule

// File: tb/bdi_codec_test.sv
module bdi_codec_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        tx_valid_i, tx_ready_o;
  logic [63:0] tx_data_i;
  logic        bus_valid_o, bus_ready_i;
  logic [63:0] bus_dat_o;
  logic [3:0]  bus_flg_o;
  logic        bus_valid_i, bus_ready_o;
  logic [63:0] bus_dat_i;
  logic [3:0]  bus_flg_i;
  logic        rx_valid_o, rx_ready_i;
  logic [63:0] rx_data_o;

  int n_run = 0;
  int n_fail = 0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #5 clk = ~clk;

  bdi_codec uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mkgrp(int cnt, int rot);
    logic [31:0] w;
    w = (32'd1 << cnt) - 32'd1;
    w = {16'd0, w[15:0]};
    w = (w << (rot % 16)) | (w >> (16 - (rot % 16)));
    return w[15:0] | w[31:16];
  endfunction

  function automatic logic [63:0] exp_lines(logic [63:0] d);
    logic [63:0] r;
    for (int g = 0; g < 4; g++)
      r[g*16 +: 16] = ($countones(d[g*16 +: 16]) > 8) ? d[g*16 +: 16] : ~d[g*16 +: 16];
    return r;
  endfunction

  function automatic logic [3:0] exp_flags(logic [63:0] d);
    logic [3:0] f;
    for (int g = 0; g < 4; g++) f[g] = !($countones(d[g*16 +: 16]) > 8);
    return f;
  endfunction

  function automatic logic [63:0] exp_dec(logic [63:0] l, logic [3:0] f);
    logic [63:0] r;
    for (int g = 0; g < 4; g++) r[g*16 +: 16] = f[g] ? ~l[g*16 +: 16] : l[g*16 +: 16];
    return r;
  endfunction

  function automatic bit lows_ok(logic [63:0] l, logic [3:0] f);
    for (int g = 0; g < 4; g++) begin
      if ($countones(~l[g*16 +: 16]) > 8) return 1'b0;
      if (!f[g] && $countones(~l[g*16 +: 16]) > 7) return 1'b0;
    end
    return 1'b1;
  endfunction

  // One round trip: encode, check, decode the captured bus beat, check, then check idle.
  task automatic round_trip(input logic [63:0] d);
    logic [63:0] cl;
    logic [3:0]  cf;
    @(negedge clk);
    tx_valid_i = 1'b1; tx_data_i = d;
    @(negedge clk);
    tx_valid_i = 1'b0;
    chk(bus_valid_o == 1'b1, "R7 tx valid after one edge", 64'(bus_valid_o), 64'd1);
    chk(bus_dat_o == exp_lines(d), "R3 R5 encoded lines", bus_dat_o, exp_lines(d));
    chk(bus_flg_o == exp_flags(d), "R2 R3 flags", 64'(bus_flg_o), 64'(exp_flags(d)));
    chk(lows_ok(bus_dat_o, bus_flg_o), "R4 lows per group", bus_dat_o, exp_lines(d));
    cl = bus_dat_o; cf = bus_flg_o;
    bus_valid_i = 1'b1; bus_dat_i = cl; bus_flg_i = cf;
    @(negedge clk);
    bus_valid_i = 1'b0;
    chk(rx_valid_o == 1'b1, "R7 rx valid after one edge", 64'(rx_valid_o), 64'd1);
    chk(rx_data_o == d, "R6 round trip", rx_data_o, d);
    chk(bus_dat_o == '1 && bus_flg_o == '1 && !bus_valid_o, "R9 tx idle",
        bus_dat_o, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  function automatic logic [63:0] next_rand(logic [63:0] x);
    x ^= x << 13; x ^= x >> 7; x ^= x << 17;
    return x;
  endfunction

  initial begin
    rst = 1'b1; tx_valid_i = 0; tx_data_i = '0; bus_ready_i = 1'b1;
    bus_valid_i = 0; bus_dat_i = '0; bus_flg_i = '0; rx_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(bus_dat_o == '1 && bus_flg_o == '1, "R10 bus idle high", bus_dat_o, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(!bus_valid_o && !rx_valid_o, "R10 valids low", 64'({bus_valid_o, rx_valid_o}), 64'd0);
    chk(rx_data_o == '0, "R10 rx data zero", rx_data_o, 64'd0);
    chk(tx_ready_o && bus_ready_o, "R10 readies high", 64'({tx_ready_o, bus_ready_o}), 64'd3);

    // R1 group position: exactly 9 ones in group 2 only flips flag bit 2
    round_trip({16'h0, 16'h01FF, 16'h0, 16'h0});
    chk(exp_flags({16'h0, 16'h01FF, 32'h0}) == 4'b1011, "R1 flag position", 64'(exp_flags({16'h0, 16'h01FF, 32'h0})), 64'hB);

    // Count sweep: every ones-count in every group, rotated placements (R3 boundary 8/9, R5)
    for (int i = 0; i <= 16; i++)
      for (int j = 0; j <= 16; j++)
        round_trip({mkgrp(16 - i, j + 3), mkgrp((i + j) % 17, i), mkgrp(j, i + 5), mkgrp(i, j)});

    // Pseudo-random words
    for (int k = 0; k < 1500; k++) begin
      lfsr = next_rand(lfsr);
      round_trip(lfsr);
    end

    // R6 arbitrary receive flags
    for (int k = 0; k < 200; k++) begin
      lfsr = next_rand(lfsr);
      @(negedge clk);
      bus_valid_i = 1'b1; bus_dat_i = lfsr; bus_flg_i = lfsr[3:0] ^ lfsr[63:60];
      @(negedge clk);
      bus_valid_i = 1'b0;
      chk(rx_data_o == exp_dec(bus_dat_i, bus_flg_i), "R6 decode by flag", rx_data_o, exp_dec(bus_dat_i, bus_flg_i));
    end

    // R8 transmit back-pressure
    @(negedge clk);
    bus_ready_i = 1'b0; tx_valid_i = 1'b1; tx_data_i = 64'hFFFF_0000_00FF_FF80;
    @(negedge clk);
    tx_data_i = 64'h1234_5678_9ABC_DEF0;
    for (int s = 0; s < 4; s++) begin
      chk(tx_ready_o == 1'b0, "R8 tx ready low in stall", 64'(tx_ready_o), 64'd0);
      chk(bus_valid_o && bus_dat_o == exp_lines(64'hFFFF_0000_00FF_FF80), "R8 tx held",
          bus_dat_o, exp_lines(64'hFFFF_0000_00FF_FF80));
      @(negedge clk);
    end
    bus_ready_i = 1'b1;
    @(negedge clk);
    tx_valid_i = 1'b0;
    chk(bus_dat_o == exp_lines(64'h1234_5678_9ABC_DEF0) && bus_flg_o == exp_flags(64'h1234_5678_9ABC_DEF0),
        "R8 waiting beat after release", bus_dat_o, exp_lines(64'h1234_5678_9ABC_DEF0));

    // R8 receive back-pressure
    @(negedge clk);
    rx_ready_i = 1'b0; bus_valid_i = 1'b1; bus_dat_i = 64'hAAAA_5555_0F0F_F0F0; bus_flg_i = 4'b0101;
    @(negedge clk);
    bus_dat_i = 64'h0;
    for (int s = 0; s < 3; s++) begin
      chk(!bus_ready_o && rx_valid_o && rx_data_o == exp_dec(64'hAAAA_5555_0F0F_F0F0, 4'b0101),
          "R8 rx held", rx_data_o, exp_dec(64'hAAAA_5555_0F0F_F0F0, 4'b0101));
      @(negedge clk);
    end
    rx_ready_i = 1'b1;
    @(negedge clk);
    bus_valid_i = 1'b0;
    chk(rx_data_o == exp_dec(64'h0, 4'b0101), "R8 rx next beat", rx_data_o, exp_dec(64'h0, 4'b0101));
    @(negedge clk);
    chk(!rx_valid_o && rx_data_o == '0, "R9 rx idle", rx_data_o, 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R7 watchdog actual=%0d cycles expected=completion", 150000);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule